// File: doc/BRIEF.md
# Interrupt-Aware Register Page Stack

This block holds the page selector that steers accesses into a paged space of special registers. Behind the live selector sit two more saved page values, which together form a three-level stack. When an interrupt is taken, the block pushes the live page down one level and loads the page that holds that interrupt's flag bits. In normal use that page is 0x00 or 0x0F, out of a 256-value selector space. When the handler returns, the stack pops and the page that was live before the interrupt comes back without any help from software.

Software reaches all three levels through a small register port. Reads are combinational. Writes never shift the stack, so a handler can rewrite the saved levels and make the return land on a different page. An interrupt entry and an interrupt return can arrive in the same cycle. In that case the entry is handled first, and the return is held as an owed pop and carried out on a later cycle that has no entry.

Top module: `pgstk_top`

## Requirements
- R1: After reset, all three levels (live, middle, bottom) read 0x00 and `curPage` is 0x00.
- R2: An `irqEnter` strobe loads the live level with `irqPage`, moves the old live value to the middle level and the old middle value to the bottom level. The old bottom value is discarded and no error is raised.
- R3: A pop moves the middle value to the live level and the bottom value to the middle level, and loads the bottom level with 0x00.
- R4: Register port address 0 selects the live level, address 1 the middle level and address 2 the bottom level. `regRdData` shows the addressed level in the same cycle. A write with `regWrEn` changes only the addressed level, one cycle later, and never shifts the stack.
- R5: Address 3 always reads 0x00, and a write to it changes no level.
- R6: A software write presented in the same cycle as a push or a pop is dropped.
- R7: When `irqEnter` and `irqReturn` are both high in one cycle, only the push happens in that cycle. The return is kept as an owed pop and runs in the first later cycle without `irqEnter`.
- R8: Owed returns are counted up to 3. Each owed return runs as its own pop, one per cycle without `irqEnter`, so a saved level that software rewrote during the handler becomes the live page after the pop.
- R9: `curPage` always equals the live level and changes in the cycle after the push, pop or write that updates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqEnter | input | 1 | Interrupt-entry strobe, one cycle per entry |
| irqReturn | input | 1 | Interrupt-return strobe, one cycle per return |
| irqPage | input | 8 | Page holding the entering interrupt's flags |
| regWrEn | input | 1 | Register-port write enable |
| regAddr | input | 2 | Register-port level select (0 live, 1 middle, 2 bottom) |
| regWrData | input | 8 | Register-port write data |
| regRdData | output | 8 | Register-port read data, combinational |
| curPage | output | 8 | Live page used for register decoding |

## Verification
Every stack update is registered, so the effect of a push, a pop or a write shows on `curPage` and the read port exactly one clock edge after the strobe. The bench drives its inputs just after a falling edge and reads all three levels during the next low phase, once that single edge has passed. An owed return has its effect one edge later than a normal return. The collision cases therefore check the stack twice: after the cycle of the push, and again after the following idle cycle in which the owed pop runs. Reads are combinational, so the bench changes `regAddr` during the low phase and samples one time step later, before the next edge.

// File: rtl/pgstk_pkg.sv
package pgstk_pkg;
  // Strobes from control to datapath; at most one of them is set in a cycle.
  typedef struct packed {
    logic push;
    logic pop;
    logic wr;
  } stackCtl_t;
endpackage

// File: rtl/pgstk_ctrl.sv
module pgstk_ctrl
  import pgstk_pkg::*;
#(
  parameter int OWE_W = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      irqEnter,
  input  logic      irqReturn,
  input  logic      regWrEn,
  input  logic      regAddrValid,
  output stackCtl_t ctl,
  output logic      owedPending
);
  localparam int SUM_W = OWE_W + 1;
  localparam logic [SUM_W-1:0] OWE_MAX = SUM_W'((1 << OWE_W) - 1);

  logic [OWE_W-1:0] owedQ;
  logic [OWE_W-1:0] owedD;
  logic [SUM_W-1:0] owedSum;
  logic [SUM_W-1:0] owedLeft;

  // Returns still owed, including the one arriving in this cycle.
  assign owedSum  = {1'b0, owedQ} + SUM_W'(irqReturn);
  assign owedLeft = owedSum - SUM_W'(1);

  always_comb begin
    ctl.push = irqEnter;
    ctl.pop  = !irqEnter && (owedSum != '0);
    ctl.wr   = regWrEn && regAddrValid && !irqEnter && !ctl.pop;
  end

  always_comb begin
    if (irqEnter) begin
      owedD = (owedSum > OWE_MAX) ? OWE_MAX[OWE_W-1:0] : owedSum[OWE_W-1:0];
    end else if (ctl.pop) begin
      owedD = owedLeft[OWE_W-1:0];
    end else begin
      owedD = owedQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) owedQ <= '0;
    else       owedQ <= owedD;
  end

  assign owedPending = (owedQ != '0);
endmodule

// File: rtl/pgstk_dpath.sv
module pgstk_dpath
  import pgstk_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int DEPTH  = 3,
  parameter int ADDR_W = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  stackCtl_t                     ctl,
  input  logic [PAGE_W-1:0]             pushPage,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [PAGE_W-1:0]             wrData,
  output logic [PAGE_W-1:0]             rdData,
  output logic [DEPTH-1:0][PAGE_W-1:0]  entries
);
  logic [DEPTH-1:0][PAGE_W-1:0] entryQ;

  for (genvar i = 0; i < DEPTH; i++) begin : g_level
    logic [PAGE_W-1:0] fromAbove;
    logic [PAGE_W-1:0] fromBelow;

    if (i == 0) begin : g_top
      assign fromAbove = pushPage;
    end else begin : g_mid
      assign fromAbove = entryQ[i-1];
    end

    if (i == DEPTH - 1) begin : g_bot
      assign fromBelow = '0;
    end else begin : g_nbot
      assign fromBelow = entryQ[i+1];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryQ[i] <= '0;
      end else if (ctl.push) begin
        entryQ[i] <= fromAbove;
      end else if (ctl.pop) begin
        entryQ[i] <= fromBelow;
      end else if (ctl.wr && (addr == ADDR_W'(i))) begin
        entryQ[i] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (addr == ADDR_W'(k)) rdData = entryQ[k];
    end
  end

  assign entries = entryQ;
endmodule

// File: rtl/pgstk_top.sv
module pgstk_top
  import pgstk_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int DEPTH  = 3,
  parameter int OWE_W  = 2,
  parameter int ADDR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqEnter,
  input  logic              irqReturn,
  input  logic [PAGE_W-1:0] irqPage,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PAGE_W-1:0] regWrData,
  output logic [PAGE_W-1:0] regRdData,
  output logic [PAGE_W-1:0] curPage
);
  stackCtl_t                    ctlStb;
  logic                         addrValid;
  logic                         owedPending;
  logic [DEPTH-1:0][PAGE_W-1:0] entryVec;

  assign addrValid = (regAddr < ADDR_W'(DEPTH));

  pgstk_ctrl #(.OWE_W(OWE_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .irqEnter     (irqEnter),
    .irqReturn    (irqReturn),
    .regWrEn      (regWrEn),
    .regAddrValid (addrValid),
    .ctl          (ctlStb),
    .owedPending  (owedPending)
  );

  pgstk_dpath #(.PAGE_W(PAGE_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctlStb),
    .pushPage (irqPage),
    .addr     (regAddr),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .entries  (entryVec)
  );

  assign curPage = entryVec[0];
endmodule

// File: rtl/pgstk_checker.sv
module pgstk_checker
  import pgstk_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int DEPTH  = 3,
  parameter int ADDR_W = 2
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         irqEnter,
  input logic                         irqReturn,
  input logic [PAGE_W-1:0]            irqPage,
  input logic [ADDR_W-1:0]            regAddr,
  input logic [PAGE_W-1:0]            curPage,
  input stackCtl_t                    ctlStb,
  input logic                         owedPending,
  input logic [DEPTH-1:0][PAGE_W-1:0] entryVec
);
  AST_PUSH_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    irqEnter |=> (curPage == $past(irqPage)) && (entryVec[1] == $past(entryVec[0]))); // R2

  AST_POP_SHIFTS: assert property (@(posedge clk) disable iff (!rstN)
    ctlStb.pop |=> (curPage == $past(entryVec[1])) && (entryVec[DEPTH-1] == '0)); // R3

  AST_WR_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStb.wr && regAddr != '0) |=> (curPage == $past(curPage))); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlStb.push && !ctlStb.pop && !ctlStb.wr) |=> $stable(entryVec)); // R5

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctlStb.push, ctlStb.pop, ctlStb.wr})); // R6

  AST_COLLIDE_DEFER: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnter && irqReturn) |=> owedPending); // R7

  AST_OWED_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (owedPending && !irqEnter) |-> ctlStb.pop); // R8
endmodule

bind pgstk_top pgstk_checker #(.PAGE_W(PAGE_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .irqEnter    (irqEnter),
  .irqReturn   (irqReturn),
  .irqPage     (irqPage),
  .regAddr     (regAddr),
  .curPage     (curPage),
  .ctlStb      (ctlStb),
  .owedPending (owedPending),
  .entryVec    (entryVec)
);

// File: tb/sim_pgstk_top.sv
`timescale 1ns/1ps
module sim_pgstk_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       irqEnter, irqReturn, regWrEn;
  logic [7:0] irqPage, regWrData;
  logic [1:0] regAddr;
  logic [7:0] regRdData, curPage;

  int checks = 0;
  int fails  = 0;

  logic [7:0] mdl [3];
  int         owed;

  always #10 clk = ~clk;

  pgstk_top u0 (
    .clk(clk), .rstN(rstN), .irqEnter(irqEnter), .irqReturn(irqReturn),
    .irqPage(irqPage), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .curPage(curPage)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Read all levels through the port during the low phase.
  task automatic checkAll(input string req);
    for (int a = 0; a < 3; a++) begin
      regAddr = 2'(a);
      #1;
      check(req, regRdData, mdl[a]);
    end
    check({req, "/R9"}, curPage, mdl[0]);
  endtask

  // Apply one cycle of stimulus and advance the reference per R2-R8.
  task automatic cycle(input logic en, input logic rt, input logic [7:0] pg,
                       input logic wr, input logic [1:0] ad, input logic [7:0] wd);
    int sum;
    irqEnter = en; irqReturn = rt; irqPage = pg;
    regWrEn = wr; regAddr = ad; regWrData = wd;
    @(posedge clk);
    sum = owed + (rt ? 1 : 0);
    if (en) begin
      mdl[2] = mdl[1]; mdl[1] = mdl[0]; mdl[0] = pg;
      owed = (sum > 3) ? 3 : sum;
    end else if (sum > 0) begin
      mdl[0] = mdl[1]; mdl[1] = mdl[2]; mdl[2] = 8'h00;
      owed = sum - 1;
    end else if (wr && ad != 2'd3) begin
      mdl[ad] = wd;
    end
    @(negedge clk);
    irqEnter = 0; irqReturn = 0; regWrEn = 0;
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rstN = 0; irqEnter = 0; irqReturn = 0; irqPage = 0;
    regWrEn = 0; regAddr = 0; regWrData = 0;
    mdl[0] = 0; mdl[1] = 0; mdl[2] = 0; owed = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    checkAll("R1 reset");

    // R4: write and read each level
    for (int a = 0; a < 3; a++) begin
      cycle(0, 0, 8'h00, 1, 2'(a), 8'h30 + 8'(a));
      checkAll("R4 write level");
    end
    // R5: address 3 reads zero, write ignored
    cycle(0, 0, 8'h00, 1, 2'd3, 8'hEE);
    regAddr = 2'd3; #1;
    check("R5 addr3 read", regRdData, 8'h00);
    checkAll("R5 addr3 write ignored");

    // R2: nested entries with the usual flag pages, fourth discards bottom
    cycle(1, 0, 8'h0F, 0, 0, 0); checkAll("R2 push1");
    cycle(1, 0, 8'h00, 0, 0, 0); checkAll("R2 push2");
    cycle(1, 0, 8'h0F, 0, 0, 0); checkAll("R2 push3");
    cycle(1, 0, 8'hA5, 0, 0, 0); checkAll("R2 push4 discard");
    // R3: pops fill bottom with zero
    for (int p = 0; p < 4; p++) begin
      cycle(0, 1, 8'h00, 0, 0, 0); checkAll("R3 pop");
    end

    // R8: handler rewrites middle level, return lands on it
    cycle(0, 0, 8'h00, 1, 2'd0, 8'h0F); checkAll("R4 set live");
    cycle(1, 0, 8'h00, 0, 0, 0);        checkAll("R2 enter");
    cycle(0, 0, 8'h00, 1, 2'd1, 8'h5A); checkAll("R8 rewrite middle");
    cycle(0, 1, 8'h00, 0, 0, 0);        checkAll("R8 return redirected");
    check("R8 live page", curPage, 8'h5A);

    // R6: writes dropped during push and pop
    cycle(1, 0, 8'h0F, 1, 2'd2, 8'hC3); checkAll("R6 write with push");
    cycle(0, 1, 8'h00, 1, 2'd1, 8'h3C); checkAll("R6 write with pop");

    // R7: collision, push first then owed pop next idle cycle
    cycle(1, 1, 8'h0F, 0, 0, 0); checkAll("R7 collide push");
    cycle(0, 0, 8'h00, 1, 2'd2, 8'h77); checkAll("R7 deferred pop");
    // R8: two collisions in a row then idles drain owed pops
    cycle(1, 1, 8'h00, 0, 0, 0); checkAll("R7 collide a");
    cycle(1, 1, 8'h0F, 0, 0, 0); checkAll("R7 collide b");
    cycle(0, 0, 8'h00, 0, 0, 0); checkAll("R8 drain 1");
    cycle(0, 0, 8'h00, 0, 0, 0); checkAll("R8 drain 2");
    cycle(0, 0, 8'h00, 0, 0, 0); checkAll("R8 idle");

    // Sweep: pseudo-random mix of all operations against the reference
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[0] & lfsr[1], lfsr[2] & lfsr[3], lfsr[4] ? 8'h0F : 8'h00,
            lfsr[5], lfsr[7:6], {lfsr[11:8], lfsr[15:12]});
      checkAll("R2/R3/R4/R6/R7 sweep");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule